// File: doc/BRIEF.md
# YUV to RGB Pixel Converter

This block converts a stream of 8-bit luma/chroma pixel triples into 8-bit red, green and blue values. Each chroma sample is first moved to a signed value around zero. The block then forms four integer products with fixed weights, shifts them right by a power of two and adds them to luma. The result of each channel is clamped to the 8-bit range. The arithmetic runs in a three-register pipeline with a valid/ready handshake at both ends. While the consumer takes results, the block accepts a new pixel on every clock.

A producer places a pixel on the input with `inValid` high. The pixel is taken on any clock edge at which `inReady` is also high. A consumer takes a result on any edge at which both `outValid` and `outReady` are high. When the consumer holds off, the whole pipeline freezes in place and the block refuses new input. No pixel is lost, duplicated or reordered.

Top module: `yuv_rgb_pipe`

## Requirements
- R1: Each chroma input (U and V, unsigned 8-bit) is turned into a signed value by subtracting 128 before it is multiplied. A chroma of 128 therefore contributes nothing.
- R2: Red is Y + ((90 × (V − 128)) arithmetically shifted right by 6). The shift rounds toward minus infinity, so V = 127 gives Y − 2.
- R3: Green is Y − ((22 × (U − 128) + 46 × (V − 128)) arithmetically shifted right by 6). The two products are summed before the shift.
- R4: Blue is Y + ((114 × (U − 128)) arithmetically shifted right by 6).
- R5: Each channel is clamped before output: a negative value gives 0 and a value above 255 gives 255. Intermediate values are signed and wide enough that no wrap-around happens before the clamp.
- R6: A pixel taken at clock edge n, with `outReady` high throughout, appears on the outputs with `outValid` high right after edge n+2. That is three register stages, the first being edge n.
- R7: While `outValid` is high and `outReady` is low, `inReady` is low, `outValid` stays high, and `outR`, `outG` and `outB` do not change.
- R8: While `outReady` stays high, one pixel is accepted on every clock. Results leave in the order the pixels arrived, with none lost or repeated.
- R9: Reset is synchronous and active high. The edge with `rst` high clears every pipeline valid flag, so after it `outValid` is 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input pixel present |
| inReady | output | 1 | Block can take an input pixel this cycle |
| inY | input | 8 | Luma sample |
| inU | input | 8 | Blue-difference chroma sample, offset by 128 |
| inV | input | 8 | Red-difference chroma sample, offset by 128 |
| outValid | output | 1 | Result pixel present |
| outReady | input | 1 | Consumer can take the result this cycle |
| outR | output | 8 | Red result |
| outG | output | 8 | Green result |
| outB | output | 8 | Blue result |

## Verification
The hardest case to reach is a stall on the output that arrives while the pipeline holds a mix of valid pixels and bubbles. In that case every stage must freeze together and still drain in order afterwards. The stimulus creates this by driving `outReady` from a pseudo-random bit stream while the producer sends pixels back to back. This creates stalls of varying length against partly filled stages. A separate phase asserts reset in the middle of such a stalled stream, to show that valid pixels left in flight are discarded. Directed pixels at the chroma extremes and at 127/129 exercise the clamp and the rounding direction of the shift.

// File: rtl/yrc_pkg.sv
package yrc_pkg;
  localparam int PIPE_STAGES = 3;

  typedef struct packed {
    logic                   advance;
    logic [PIPE_STAGES-1:0] load;
  } yrcStrobe_t;
endpackage

// File: rtl/yrc_clamp.sv
module yrc_clamp #(
  parameter int PIX_W = 8,
  parameter int IN_W  = 19
) (
  input  logic signed [IN_W-1:0] din,
  output logic [PIX_W-1:0]       dout
);
  localparam logic signed [IN_W-1:0] MAXV = IN_W'((1 << PIX_W) - 1);

  always_comb begin
    if (din < 0)
      dout = '0;
    else if (din > MAXV)
      dout = '1;
    else
      dout = din[PIX_W-1:0];
  end
endmodule

// File: rtl/yrc_ctrl.sv
module yrc_ctrl
  import yrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output yrcStrobe_t strobe
);
  logic [PIPE_STAGES-1:0] vld;

  assign strobe.advance = ~(vld[PIPE_STAGES-1] & ~outReady);
  assign inReady        = strobe.advance;
  assign outValid       = vld[PIPE_STAGES-1];

  genvar i;
  generate
    for (i = 0; i < PIPE_STAGES; i++) begin : g_load
      if (i == 0) begin : g_first
        assign strobe.load[i] = strobe.advance & inValid;
      end else begin : g_rest
        assign strobe.load[i] = strobe.advance & vld[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      vld <= '0;
    else if (strobe.advance)
      vld <= {vld[PIPE_STAGES-2:0], inValid};
  end

  AST_STALL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> outValid); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && inReady)); // R9
endmodule

// File: rtl/yrc_dpath.sv
module yrc_dpath
  import yrc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int K_RV   = 90,
  parameter int K_GU   = 22,
  parameter int K_GV   = 46,
  parameter int K_BU   = 114,
  parameter int SHIFT  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  yrcStrobe_t       strobe,
  input  logic [PIX_W-1:0] inY,
  input  logic [PIX_W-1:0] inU,
  input  logic [PIX_W-1:0] inV,
  output logic [PIX_W-1:0] outR,
  output logic [PIX_W-1:0] outG,
  output logic [PIX_W-1:0] outB
);
  localparam int CW   = PIX_W + 1;
  localparam int PW   = CW + COEF_W + 1;
  localparam int SW   = PW + 1;
  localparam int RW   = SW + 1;
  localparam int BIAS = 1 << (PIX_W - 1);
  localparam int NCH  = 3;

  localparam logic signed [COEF_W:0] C_RV = (COEF_W+1)'(K_RV);
  localparam logic signed [COEF_W:0] C_GU = (COEF_W+1)'(K_GU);
  localparam logic signed [COEF_W:0] C_GV = (COEF_W+1)'(K_GV);
  localparam logic signed [COEF_W:0] C_BU = (COEF_W+1)'(K_BU);

  // stage 1: centre chroma
  logic signed [CW-1:0] cU, cV;
  logic signed [CW-1:0] s1U, s1V;
  logic [PIX_W-1:0]     s1Y;

  always_comb begin
    cU = CW'({1'b0, inU}) - CW'(BIAS);
    cV = CW'({1'b0, inV}) - CW'(BIAS);
  end

  always_ff @(posedge clk) begin
    if (strobe.load[0]) begin
      s1Y <= inY;
      s1U <= cU;
      s1V <= cV;
    end
  end

  // stage 2: constant products
  logic signed [PW-1:0] mRV, mGU, mGV, mBU;
  logic [PIX_W-1:0]     s2Y;

  always_ff @(posedge clk) begin
    if (strobe.load[1]) begin
      s2Y <= s1Y;
      mRV <= PW'(s1V) * PW'(C_RV);
      mGU <= PW'(s1U) * PW'(C_GU);
      mGV <= PW'(s1V) * PW'(C_GV);
      mBU <= PW'(s1U) * PW'(C_BU);
    end
  end

  // stage 3: sum, shift, add luma, clamp
  logic signed [SW-1:0] sumG;
  logic signed [RW-1:0] yExt;
  logic signed [RW-1:0] raw [NCH];
  logic [PIX_W-1:0]     clampd [NCH];

  always_comb begin
    sumG   = SW'(mGU) + SW'(mGV);
    yExt   = RW'($signed({1'b0, s2Y}));
    raw[0] = yExt + RW'(mRV >>> SHIFT);
    raw[1] = yExt - RW'(sumG >>> SHIFT);
    raw[2] = yExt + RW'(mBU >>> SHIFT);
  end

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_clamp
      yrc_clamp #(.PIX_W(PIX_W), .IN_W(RW)) u_clamp (
        .din (raw[ch]),
        .dout(clampd[ch])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.load[2]) begin
      outR <= clampd[0];
      outG <= clampd[1];
      outB <= clampd[2];
    end
  end

  AST_CHROMA_CENTRE: assert property (@(posedge clk) disable iff (rst)
    (strobe.load[0] && inU == PIX_W'(BIAS)) |=> (s1U == 0)); // R1

  AST_RED_SIGN: assert property (@(posedge clk) disable iff (rst)
    (strobe.load[1] && s1V < 0) |=> (mRV < 0)); // R2

  AST_BLUE_SIGN: assert property (@(posedge clk) disable iff (rst)
    (strobe.load[1] && s1U > 0) |=> (mBU > 0)); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.advance |=> ($stable(outR) && $stable(outG) && $stable(outB))); // R7
endmodule

// File: rtl/yuv_rgb_pipe.sv
module yuv_rgb_pipe
  import yrc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int K_RV   = 90,
  parameter int K_GU   = 22,
  parameter int K_GV   = 46,
  parameter int K_BU   = 114,
  parameter int SHIFT  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic [PIX_W-1:0] inY,
  input  logic [PIX_W-1:0] inU,
  input  logic [PIX_W-1:0] inV,
  output logic             outValid,
  input  logic             outReady,
  output logic [PIX_W-1:0] outR,
  output logic [PIX_W-1:0] outG,
  output logic [PIX_W-1:0] outB
);
  yrcStrobe_t strobe;

  yrc_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  yrc_dpath #(
    .PIX_W (PIX_W),
    .COEF_W(COEF_W),
    .K_RV  (K_RV),
    .K_GU  (K_GU),
    .K_GV  (K_GV),
    .K_BU  (K_BU),
    .SHIFT (SHIFT)
  ) u_dpath (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .inY   (inY),
    .inU   (inU),
    .inV   (inV),
    .outR  (outR),
    .outG  (outG),
    .outB  (outB)
  );
endmodule

// File: tb/sim_yuv_rgb_pipe.sv
`timescale 1ns/1ps
module sim_yuv_rgb_pipe;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] inY = '0, inU = '0, inV = '0;
  logic       outValid;
  logic       outReady = 1'b1;
  logic [7:0] outR, outG, outB;

  int checks = 0;
  int errors = 0;
  logic [23:0] expQ [$];
  logic        stallMode = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  logic        finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  yuv_rgb_pipe u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inY(inY), .inU(inU), .inV(inV), .outValid(outValid),
    .outReady(outReady), .outR(outR), .outG(outG), .outB(outB)
  );

  function automatic int clampPix(input int x);
    if (x < 0) return 0;
    if (x > 255) return 255;
    return x;
  endfunction

  // R1..R5 reference model
  function automatic logic [23:0] refPix(input int y, input int u, input int v);
    int uc, vc, r, g, b;
    uc = u - 128;
    vc = v - 128;
    r = y + ((90 * vc) >>> 6);
    g = y - ((22 * uc + 46 * vc) >>> 6);
    b = y + ((114 * uc) >>> 6);
    return {8'(clampPix(r)), 8'(clampPix(g)), 8'(clampPix(b))};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendPix(input int y, input int u, input int v);
    @(negedge clk);
    inValid = 1'b1;
    inY = 8'(y); inU = 8'(u); inV = 8'(v);
    forever begin
      #3;
      if (inReady) begin
        expQ.push_back(refPix(y, u, v));
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idleIn();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // output ready driver
  always @(negedge clk) begin
    seed = seed * 32'd1664525 + 32'd1013904223;
    outReady = stallMode ? seed[17] : 1'b1;
  end

  // monitor / scoreboard
  logic        prevStall = 1'b0;
  logic [23:0] heldPix;
  always @(negedge clk) begin
    #3;
    if (rst) begin
      prevStall = 1'b0;
    end else begin
      if (prevStall) begin
        check(outValid === 1'b1, "R7 valid held", int'(outValid), 1);
        check({outR, outG, outB} === heldPix, "R7 data held",
              int'({outR, outG, outB}), int'(heldPix));
      end
      if (outValid && !outReady) begin
        check(inReady === 1'b0, "R7 inReady low", int'(inReady), 0);
        prevStall = 1'b1;
        heldPix = {outR, outG, outB};
      end else begin
        prevStall = 1'b0;
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected output", int'({outR, outG, outB}), -1);
        end else begin
          logic [23:0] e;
          e = expQ.pop_front();
          // R2 R3 R4 R5 R8: value and order
          check({outR, outG, outB} === e, "R2/R3/R4/R5/R8 pixel",
                int'({outR, outG, outB}), int'(e));
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #3;
    // R9: state after reset
    check(outValid === 1'b0, "R9 outValid after reset", int'(outValid), 0);
    check(inReady === 1'b1, "R9 inReady after reset", int'(inReady), 1);

    // R6: latency with empty pipeline
    sendPix(90, 128, 128);
    idleIn();
    #3;
    cnt = 1;
    while (!outValid && cnt < 10) begin
      @(negedge clk); #3;
      cnt++;
    end
    check(cnt == 3, "R6 latency samples", cnt, 3);
    repeat (3) @(negedge clk);

    // R1..R5 directed corners
    sendPix(128, 128, 128); // R1 neutral chroma
    sendPix(0, 0, 0);       // R5 low clamp on R and B, G = 136
    sendPix(255, 255, 255); // R5 high clamp
    sendPix(100, 128, 127); // R2 floor: 98
    sendPix(100, 128, 129); // R2: 101
    sendPix(100, 127, 128); // R3/R4 floor
    sendPix(60, 200, 30);   // R3 mixed signs
    sendPix(10, 255, 128);  // R4 strong blue
    sendPix(250, 0, 255);   // R2 high, R4 low
    idleIn();
    repeat (6) @(negedge clk);
    check(expQ.size() == 0, "R8 directed drained", expQ.size(), 0);

    // R8: back-to-back stream, no stall
    for (int i = 0; i < 40; i++)
      sendPix((i * 37) & 255, (i * 91 + 5) & 255, (i * 53 + 200) & 255);
    idleIn();
    repeat (6) @(negedge clk);
    check(expQ.size() == 0, "R8 stream drained", expQ.size(), 0);

    // R7: random output stalls
    stallMode = 1'b1;
    for (int i = 0; i < 150; i++) begin
      sendPix((i * 113 + 7) & 255, (i * 29) & 255, (i * 71 + 3) & 255);
      if (i % 17 == 0) idleIn();
    end
    idleIn();
    stallMode = 1'b0;
    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R7/R8 stalled stream drained", expQ.size(), 0);

    // R9: reset while stalled and full
    stallMode = 1'b1;
    for (int i = 0; i < 6; i++) sendPix(i * 40, 255 - i * 30, i * 20);
    idleIn();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #3;
    check(outValid === 1'b0, "R9 mid-run reset clears valid", int'(outValid), 0);
    check(inReady === 1'b1, "R9 mid-run reset inReady", int'(inReady), 1);
    expQ.delete();
    stallMode = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    #3;
    check(outValid === 1'b0, "R9 no stale output", int'(outValid), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule